// File: doc/BRIEF.md
# Status and Readback Select Logic

This block keeps the control-derived state of a converter's serial register interface and decides which 16-bit word is presented for the next read cycle. A control-word write strobe latches a set of configuration fields: input configuration, channel, power management, read source, interface mode and calibration settings. The two read-source bits of that write choose whether reads return the status word, the calibration register bank, or a conversion-result placeholder.

The status word is assembled from the latched fields, two live flags from the conversion/calibration sequencer (busy and calibration-active), and fixed bits. The source choice is held in a small state machine with three states: `SRC_RESULT` (reset state), `SRC_CALBANK` and `SRC_STATUS`. Each control write takes one of three transitions, select-result, select-calbank or select-status, chosen by the written read-source bits. With no write, the state holds. Each read cycle clears the interface-mode field. When a write and a read cycle land in the same clock, the write applies first and the clear then wins for the mode field.

Top module: `rdback_sel`

## Requirements
- R1: After reset every latched field is 0 and the source state is `SRC_RESULT`, so `rd_word` equals `conv_result`. Selecting the status word with no other field set then reads 16'h00C0 while both live flags are 0.
- R2: The read-source field is control bits [7:6]. A write of 2'b11 returns the status word, 2'b10 returns `cal_word`, and 2'b00 or 2'b01 return `conv_result`, starting the cycle after the write.
- R3: Status bit 15 and status bit 4 always read 0.
- R4: Status bit 14 equals `busy` OR `cal_active` in the same cycle. It is live, not latched.
- R5: Status bit 0 equals `cal_active` in the same cycle.
- R6: Status bit 13 is the single/differential flag, bits 12:10 the channel and bits 9:8 the power-management pair. Each is latched from the control bit in the same position.
- R7: Status bits 7:6 always read 2'b11 whenever the status word is returned.
- R8: Status bit 5 is the interface mode, latched from control bit 5 and cleared to 0 the cycle after any read-cycle strobe. Status bits 3 and 2:1 are the calibration mode and calibration select, latched from control bits 3 and 2:1.
- R9: A control write and a read-cycle strobe in the same clock apply the write to all fields and the source, then leave the interface mode at 0.
- R10: Control bits 15, 14, 4 and 0 are ignored. A read-cycle strobe changes no field other than the interface mode, and without a write no field or source changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_data | input | 16 | Control word written with the strobe |
| rd_cycle | input | 1 | One-clock strobe marking a completed read cycle |
| busy | input | 1 | Conversion in progress, from the sequencer |
| cal_active | input | 1 | Calibration in progress, from the sequencer |
| conv_result | input | 16 | Conversion-result placeholder word |
| cal_word | input | 16 | Word from the calibration register bank |
| rd_word | output | 16 | Word returned on the next read cycle |

## Verification
A table of control words walks every read-source code together with field patterns: all ones, all zeros, a sparse channel/calibration mix and a set-mode mix. Each of these words is paired with different busy and calibration flags, so that a swapped field position, a latched flag or a wrong source decode produces a distinct word. Directed cases then check the reset word, clearing the mode with and without a same-cycle write, and toggling the live flags with no write. A write that sets only the ignored bits shows whether those bits leak into the status word.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int WORD_W  = 16;
    localparam int CHAN_W  = 3;
    localparam int PWR_W   = 2;
    localparam int SEL_W   = 2;
    localparam int CALS_W  = 2;

    // bit positions shared by control word and status word
    localparam int P_BIT_ZERO = 15;
    localparam int P_BIT_BUSY = 14;
    localparam int P_SGL      = 13;
    localparam int P_CHAN_LO  = 10;
    localparam int P_PWR_LO   = 8;
    localparam int P_SEL_LO   = 6;
    localparam int P_MODE     = 5;
    localparam int P_DONTCARE = 4;
    localparam int P_CALMODE  = 3;
    localparam int P_CALS_LO  = 1;
    localparam int P_CALRUN   = 0;

    localparam logic [SEL_W-1:0] SEL_STATUS  = 2'b11;
    localparam logic [SEL_W-1:0] SEL_CALBANK = 2'b10;

    typedef enum logic [1:0] {
        SRC_RESULT  = 2'd0,
        SRC_CALBANK = 2'd1,
        SRC_STATUS  = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic              sgl;
        logic [CHAN_W-1:0] chan;
        logic [PWR_W-1:0]  pwr;
        logic [SEL_W-1:0]  rd_sel;
        logic              if_mode;
        logic              cal_mode;
        logic [CALS_W-1:0] cal_sel;
    } ctrl_fields_t;
endpackage

// File: rtl/ssr_field_latch.sv
module ssr_field_latch
    import ssr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               rd_pulse,
    output ctrl_fields_t       fields
);
    ctrl_fields_t decoded;

    always_comb begin
        decoded          = '0;
        decoded.sgl      = wr_word[P_SGL];
        decoded.chan     = wr_word[P_CHAN_LO +: CHAN_W];
        decoded.pwr      = wr_word[P_PWR_LO +: PWR_W];
        decoded.rd_sel   = wr_word[P_SEL_LO +: SEL_W];
        decoded.if_mode  = wr_word[P_MODE];
        decoded.cal_mode = wr_word[P_CALMODE];
        decoded.cal_sel  = wr_word[P_CALS_LO +: CALS_W];
    end

    // write first, then the read-cycle clear of the mode bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields <= '0;
        end else begin
            if (wr_en)
                fields <= decoded;
            if (rd_pulse)
                fields.if_mode <= 1'b0;
        end
    end

    assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !fields.if_mode);

    assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_pulse) |=> (fields.chan == $past(wr_word[P_CHAN_LO +: CHAN_W])) && !fields.if_mode);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_pulse) |=> $stable(fields));

    assert_read_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_pulse) |=> (fields.chan == $past(fields.chan)) && (fields.cal_sel == $past(fields.cal_sel)));
endmodule

// File: rtl/ssr_src_fsm.sv
module ssr_src_fsm
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    output rd_src_e           state
);
    rd_src_e state_nx;

    always_comb begin
        state_nx = state;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_STATUS:  state_nx = SRC_STATUS;
                SEL_CALBANK: state_nx = SRC_CALBANK;
                default:     state_nx = SRC_RESULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SRC_RESULT;
        else
            state <= state_nx;
    end

    assert_to_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_STATUS) |=> state == SRC_STATUS);

    assert_to_calbank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CALBANK) |=> state == SRC_CALBANK);

    assert_state_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state));
endmodule

// File: rtl/ssr_status_pack.sv
module ssr_status_pack
    import ssr_pkg::*;
(
    input  ctrl_fields_t       fields,
    input  logic               busy,
    input  logic               cal_active,
    output logic [WORD_W-1:0]  status_word
);
    always_comb begin
        status_word                           = '0;
        status_word[P_BIT_ZERO]               = 1'b0;
        status_word[P_BIT_BUSY]               = busy | cal_active;
        status_word[P_SGL]                    = fields.sgl;
        status_word[P_CHAN_LO +: CHAN_W]      = fields.chan;
        status_word[P_PWR_LO +: PWR_W]        = fields.pwr;
        status_word[P_SEL_LO +: SEL_W]        = SEL_STATUS;
        status_word[P_MODE]                   = fields.if_mode;
        status_word[P_DONTCARE]               = 1'b0;
        status_word[P_CALMODE]                = fields.cal_mode;
        status_word[P_CALS_LO +: CALS_W]      = fields.cal_sel;
        status_word[P_CALRUN]                 = cal_active;
    end
endmodule

// File: rtl/rdback_sel.sv
module rdback_sel
    import ssr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [WORD_W-1:0]  ctrl_data,
    input  logic               rd_cycle,
    input  logic               busy,
    input  logic               cal_active,
    input  logic [WORD_W-1:0]  conv_result,
    input  logic [WORD_W-1:0]  cal_word,
    output logic [WORD_W-1:0]  rd_word
);
    ctrl_fields_t       fields;
    rd_src_e            src_state;
    logic [WORD_W-1:0]  status_word;

    ssr_field_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wr_word  (ctrl_data),
        .rd_pulse (rd_cycle),
        .fields   (fields)
    );

    ssr_src_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wr_sel (ctrl_data[P_SEL_LO +: SEL_W]),
        .state  (src_state)
    );

    ssr_status_pack u_pack (
        .fields      (fields),
        .busy        (busy),
        .cal_active  (cal_active),
        .status_word (status_word)
    );

    always_comb begin
        unique case (src_state)
            SRC_STATUS:  rd_word = status_word;
            SRC_CALBANK: rd_word = cal_word;
            default:     rd_word = conv_result;
        endcase
    end

    assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == SRC_STATUS) |-> (!rd_word[P_BIT_ZERO] && !rd_word[P_DONTCARE]));

    assert_live_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == SRC_STATUS) |-> (rd_word[P_BIT_BUSY] == (busy || cal_active)));

    assert_cal_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == SRC_STATUS) |-> (rd_word[P_CALRUN] == cal_active));

    assert_sel_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == SRC_STATUS) |-> (rd_word[P_SEL_LO +: SEL_W] == 2'b11));

    assert_result_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_state == SRC_RESULT) |-> (rd_word == conv_result));
endmodule

// File: tb/rdback_sel_bench.sv
module rdback_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_data = '0;
    logic        rd_cycle = 1'b0;
    logic        busy = 1'b0;
    logic        cal_active = 1'b0;
    logic [15:0] conv_result = 16'hA5A5;
    logic [15:0] cal_word = 16'h3C3C;
    logic [15:0] rd_word;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rdback_sel u_rdback_sel (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .rd_cycle(rd_cycle), .busy(busy), .cal_active(cal_active),
        .conv_result(conv_result), .cal_word(cal_word), .rd_word(rd_word)
    );

    // {control word, busy, cal_active, expected rd_word}
    localparam int NV = 10;
    localparam logic [33:0] VEC [NV] = '{
        {16'h00C0, 1'b0, 1'b0, 16'h00C0},
        {16'h3FFF, 1'b0, 1'b0, 16'h3FEE},
        {16'h3FFF, 1'b1, 1'b0, 16'h7FEE},
        {16'hFFFF, 1'b0, 1'b1, 16'h7FEF},
        {16'h2480, 1'b1, 1'b1, 16'h3C3C},
        {16'h0040, 1'b1, 1'b0, 16'hA5A5},
        {16'h0000, 1'b0, 1'b0, 16'hA5A5},
        {16'h14C6, 1'b0, 1'b0, 16'h14C6},
        {16'h14C6, 1'b0, 1'b1, 16'h54C7},
        {16'h2BE8, 1'b1, 1'b0, 16'h6BE8}
    };

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (rd_word !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_word=%h expected=%h", req, rd_word, exp);
        end
    endtask

    // one-clock write (optionally with a read strobe), sampled at the following negedge
    task automatic wr(input logic [15:0] d, input logic rd);
        @(negedge clk);
        ctrl_data = d; ctrl_wr = 1'b1; rd_cycle = rd;
        @(negedge clk);
        ctrl_wr = 1'b0; rd_cycle = 1'b0;
        #1;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rd_cycle = 1'b1;
        @(negedge clk);
        rd_cycle = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset holds result source", 16'hA5A5);
        rst_n = 1'b1;
        #1;
        check("R1 result source after reset release", 16'hA5A5);
        wr(16'h00C0, 1'b0);
        check("R1 status word with cleared fields", 16'h00C0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            busy = VEC[i][17];
            cal_active = VEC[i][16];
            wr(VEC[i][33:18], 1'b0);
            check("R2/R3/R4/R5/R6/R7/R8 table vector", VEC[i][15:0]);
        end
        busy = 1'b0; cal_active = 1'b0;

        // R2: result placeholder and cal bank are live inputs
        wr(16'h0000, 1'b0);
        conv_result = 16'h1234; #1;
        check("R2 result placeholder follows input", 16'h1234);
        wr(16'h0080, 1'b0);
        cal_word = 16'h0ABC; #1;
        check("R2 cal bank word", 16'h0ABC);

        // R8: read strobe clears mode
        wr(16'h00E0, 1'b0);
        check("R8 mode set", 16'h00E0);
        rd_pulse();
        check("R8 mode cleared by read", 16'h00C0);

        // R10: read keeps other fields
        wr(16'h3FEE, 1'b0);
        check("R10 full fields before read", 16'h3FEE);
        rd_pulse();
        check("R10 read keeps fields except mode", 16'h3FCE);

        // R9: write and read in the same clock
        wr(16'h14E6, 1'b1);
        check("R9 write applies then mode clears", 16'h14C6);

        // R4/R5: live flags with no write
        busy = 1'b1; #1;
        check("R4 busy live", 16'h54C6);
        busy = 1'b0; cal_active = 1'b1; #1;
        check("R4/R5 cal flag live", 16'h54C7);
        cal_active = 1'b0; #1;
        check("R4/R5 flags dropped", 16'h14C6);

        // R10: ignored control bits
        wr(16'hC0D1, 1'b0);
        check("R10 ignored control bits", 16'h00C0);
        repeat (3) @(negedge clk);
        #1;
        check("R10 no change without write", 16'h00C0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule